// File: doc/BRIEF.md
# Configurable-precision floating-point operand unpacker

This block is the first stage of a shared floating-point datapath. On each clock it can take one opcode and two packed operands. All three are held in an input register. From the held operands it produces a common unpacked form for the arithmetic units that follow: sign, extended mantissa, extended exponent and a five-bit classification vector per operand.

Every format handled by the block has an 8-bit exponent. The stored mantissa width is a design-time parameter from 1 to 23 bits. A narrow mantissa sits at the top of a 23-bit field, with zeros below it. Because every format shares one exponent range, a 16-bit brain-float style operand and a full single-precision operand unpack to the same shape.

A packed operand holds the sign in its MSB, then the 8 exponent bits, then the mantissa in its low bits.

Top module: `fp_operand_unpacker`

## Requirements
- R1: On a rising edge with `in_valid` high, the block captures the opcode and both operands. From the next cycle their decoded form appears on the outputs, with `out_opcode` equal to the captured opcode. `out_valid` is high exactly in the cycle after each accepted operation, so back-to-back operations are accepted one per clock.
- R2: On an edge with `in_valid` low, the held opcode and operands do not change. All decoded outputs keep their values while the inputs move, and `out_valid` is low in the next cycle.
- R3: After synchronous active-low reset, `out_valid` is 0 and both operands decode as positive zero: sign 0, exponent 0, mantissa 0, and only the zero flag set.
- R4: The stored mantissa fills bits 22 down to 23-MANT_W of the 23-bit field, and the bits below that are 0. The 24-bit extended mantissa carries the hidden bit in bit 23 above that field.
- R5: For an exponent from 1 to 254, the hidden bit is 1, the extended exponent equals the stored exponent, and no flag is set.
- R6: For exponent 0 and mantissa 0, flag bit 0 (zero) is set, the hidden bit is 0 and the extended exponent is 0. The sign still passes through.
- R7: For exponent 0 and a nonzero mantissa, flag bit 4 (subnormal) is set and the hidden bit is 0. The extended exponent is 1, which is the minimum normal exponent.
- R8: For exponent 255 and mantissa 0, flag bit 1 (infinity) is set, the hidden bit is 1 and the extended exponent is 255.
- R9: For exponent 255 and a nonzero mantissa, the operand is a NaN with hidden bit 1. Flag bit 3 (quiet) is set when bit 22 of the padded field is 1. Otherwise flag bit 2 (signalling) is set.
- R10: At most one flag bit is set per operand. The two operands are classified independently in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Qualifies capture of opcode and operands |
| in_opcode | input | OPC_W | Operation code to carry along |
| in_a | input | 9+MANT_W | Packed first operand |
| in_b | input | 9+MANT_W | Packed second operand |
| out_valid | output | 1 | Held operation is newly presented |
| out_opcode | output | OPC_W | Held opcode |
| out_a_sign | output | 1 | Sign of first operand |
| out_a_mant | output | 24 | Hidden bit and padded mantissa of first operand |
| out_a_exp | output | 8 | Extended exponent of first operand |
| out_a_flags | output | 5 | Class of first operand: bit0 zero, bit1 inf, bit2 sNaN, bit3 qNaN, bit4 subnormal |
| out_b_sign | output | 1 | Sign of second operand |
| out_b_mant | output | 24 | Hidden bit and padded mantissa of second operand |
| out_b_exp | output | 8 | Extended exponent of second operand |
| out_b_flags | output | 5 | Class of second operand, same encoding |

## Verification
Two functions can fall in the same cycle.

The first is the capture of a new operation while the previous one is still being presented. It is provoked by driving two operations on consecutive edges. Each result must show up one cycle after its own capture, with its own opcode and no mixing.

The second is the classification of the two operands when they belong to different classes. It is provoked by pairing a subnormal with a NaN, or a zero with an infinity, in a single operation. Each side must carry its own single flag and its own exponent adjustment.

// File: rtl/fpu_unpack_pkg.sv
// Shared constants and the classification type for the operand unpacker.
// Assumes a fixed 8-bit exponent and a 23-bit full mantissa field.
package fpu_unpack_pkg;
    localparam int EXP_W       = 8;
    localparam int FULL_MANT_W = 23;
    localparam int EXT_MANT_W  = FULL_MANT_W + 1;
    localparam int FLAG_W      = 5;

    // Classification flags; is_zero is bit 0, is_sub is bit 4.
    typedef struct packed {
        logic is_sub;
        logic is_qnan;
        logic is_snan;
        logic is_inf;
        logic is_zero;
    } fp_class_t;
endpackage

// File: rtl/fpu_unpack_inreg.sv
// Input register with valid qualifier.
// Captures the data word on an edge where in_valid is high and holds it otherwise.
// q_valid is high for exactly the cycle after a capture.
// Assumes a synchronous active-low reset that clears both data and valid.
module fpu_unpack_inreg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         q_valid
);
    // Capture or hold the data word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (in_valid) begin
            q <= d;
        end
    end

    // One-cycle valid that follows each capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
        end else begin
            q_valid <= in_valid;
        end
    end
endmodule

// File: rtl/fpu_unpack_class.sv
// Combinational unpacker for one packed operand.
// Widens the mantissa to 23 bits by zero-filling its low end and adds the hidden bit.
// Raises the subnormal exponent to 1 and classifies the operand.
// Assumes the packed layout {sign, 8-bit exponent, MANT_W-bit mantissa}, with 1 <= MANT_W <= 23.
module fpu_unpack_class
    import fpu_unpack_pkg::*;
#(
    parameter int MANT_W = 23,
    localparam int PACK_W = 1 + EXP_W + MANT_W,
    localparam int PAD_W  = FULL_MANT_W - MANT_W
) (
    input  logic [PACK_W-1:0]     op_i,
    output logic                  sign_o,
    output logic [EXT_MANT_W-1:0] mant_o,
    output logic [EXP_W-1:0]      exp_o,
    output fp_class_t             class_o
);
    logic [EXP_W-1:0]       raw_exp;
    logic [MANT_W-1:0]      raw_mant;
    logic [FULL_MANT_W-1:0] padded;
    logic                   exp_zero;
    logic                   exp_ones;
    logic                   mant_nz;

    // Field split of the packed word.
    assign sign_o   = op_i[PACK_W-1];
    assign raw_exp  = op_i[PACK_W-2 -: EXP_W];
    assign raw_mant = op_i[MANT_W-1:0];

    // Pick the widening variant for full or reduced precision.
    generate
        if (PAD_W == 0) begin : g_full
            assign padded = raw_mant;
        end else begin : g_pad
            assign padded = {raw_mant, {PAD_W{1'b0}}};
        end
    endgenerate

    // Exponent and mantissa summary terms.
    always_comb begin
        exp_zero = (raw_exp == '0);
        exp_ones = &raw_exp;
        mant_nz  = |padded;
    end

    // Classification of the operand.
    always_comb begin
        class_o         = '0;
        class_o.is_zero = exp_zero && !mant_nz;
        class_o.is_sub  = exp_zero && mant_nz;
        class_o.is_inf  = exp_ones && !mant_nz;
        class_o.is_qnan = exp_ones && padded[FULL_MANT_W-1];
        class_o.is_snan = exp_ones && !padded[FULL_MANT_W-1] && mant_nz;
    end

    // Hidden bit and exponent adjustment for subnormals.
    always_comb begin
        mant_o = {!exp_zero, padded};
        exp_o  = raw_exp | {{(EXP_W-1){1'b0}}, class_o.is_sub};
    end
endmodule

// File: rtl/fp_operand_unpacker.sv
// Top of the operand unpacker.
// Registers the opcode and two packed operands at the input. The held operands are unpacked
// into sign, 24-bit extended mantissa, extended exponent and class flags.
// Assumes at most one new operation per clock, qualified by in_valid.
module fp_operand_unpacker
    import fpu_unpack_pkg::*;
#(
    parameter int MANT_W = 23,
    parameter int OPC_W  = 4,
    localparam int PACK_W = 1 + EXP_W + MANT_W,
    localparam int NUM_OP = 2,
    localparam int REG_W  = OPC_W + NUM_OP * PACK_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [OPC_W-1:0]      in_opcode,
    input  logic [PACK_W-1:0]     in_a,
    input  logic [PACK_W-1:0]     in_b,
    output logic                  out_valid,
    output logic [OPC_W-1:0]      out_opcode,
    output logic                  out_a_sign,
    output logic [EXT_MANT_W-1:0] out_a_mant,
    output logic [EXP_W-1:0]      out_a_exp,
    output logic [FLAG_W-1:0]     out_a_flags,
    output logic                  out_b_sign,
    output logic [EXT_MANT_W-1:0] out_b_mant,
    output logic [EXP_W-1:0]      out_b_exp,
    output logic [FLAG_W-1:0]     out_b_flags
);
    logic [REG_W-1:0]      held;
    logic [PACK_W-1:0]     op_q   [NUM_OP];
    logic                  sign_w [NUM_OP];
    logic [EXT_MANT_W-1:0] mant_w [NUM_OP];
    logic [EXP_W-1:0]      exp_w  [NUM_OP];
    fp_class_t             cls_w  [NUM_OP];

    fpu_unpack_inreg #(.W(REG_W)) u_inreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .d        ({in_opcode, in_a, in_b}),
        .q        (held),
        .q_valid  (out_valid)
    );

    // Split the held word into opcode and operands.
    assign out_opcode = held[REG_W-1 -: OPC_W];
    assign op_q[0]    = held[2*PACK_W-1 -: PACK_W];
    assign op_q[1]    = held[PACK_W-1:0];

    // One unpacker per operand.
    generate
        for (genvar k = 0; k < NUM_OP; k++) begin : g_op
            fpu_unpack_class #(.MANT_W(MANT_W)) u_class (
                .op_i    (op_q[k]),
                .sign_o  (sign_w[k]),
                .mant_o  (mant_w[k]),
                .exp_o   (exp_w[k]),
                .class_o (cls_w[k])
            );
        end
    endgenerate

    // Drive the per-operand output ports.
    always_comb begin
        out_a_sign  = sign_w[0];
        out_a_mant  = mant_w[0];
        out_a_exp   = exp_w[0];
        out_a_flags = cls_w[0];
        out_b_sign  = sign_w[1];
        out_b_mant  = mant_w[1];
        out_b_exp   = exp_w[1];
        out_b_flags = cls_w[1];
    end
endmodule

// File: rtl/fpu_unpack_checker.sv
// Property checker for the operand unpacker, attached by bind.
// Assumes the flag encoding bit0 zero, bit1 inf, bit2 sNaN, bit3 qNaN, bit4 subnormal.
module fpu_unpack_checker #(
    parameter int MANT_W = 23,
    localparam int PAD_W = 23 - MANT_W
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        out_valid,
    input logic [23:0] out_a_mant,
    input logic [7:0]  out_a_exp,
    input logic [4:0]  out_a_flags,
    input logic [23:0] out_b_mant,
    input logic [7:0]  out_b_exp,
    input logic [4:0]  out_b_flags
);
    // R1: an accepted operation is presented in the next cycle.
    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1: out_valid is never raised without a capture one cycle earlier.
    assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    // R2: without a capture, the decoded operands stay unchanged.
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_a_mant) && $stable(out_b_mant)
                       && $stable(out_a_flags) && $stable(out_b_flags)));

    // R10: at most one class flag per operand.
    assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_a_flags) && $onehot0(out_b_flags));

    // R6: zero has no hidden bit, an empty mantissa and exponent 0.
    assert_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_a_flags[0] |-> (out_a_mant == 24'd0 && out_a_exp == 8'd0));

    // R7: subnormal has no hidden bit and the minimum normal exponent.
    assert_sub_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_a_flags[4] |-> (!out_a_mant[23] && out_a_exp == 8'd1 && out_a_mant[22:0] != 23'd0));

    // R8: infinity has the hidden bit only and exponent 255.
    assert_inf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_b_flags[1] |-> (out_b_mant == 24'h800000 && out_b_exp == 8'hFF));

    // R9: both NaN kinds carry exponent 255 and the hidden bit.
    assert_nan_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_a_flags[2] || out_a_flags[3]) |-> (out_a_exp == 8'hFF && out_a_mant[23]));

    // R5: an unflagged operand is normal, with the hidden bit set and an exponent inside 1..254.
    assert_normal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_b_flags == 5'd0) |-> (out_b_mant[23] && out_b_exp != 8'd0 && out_b_exp != 8'hFF));

    // R4: the padding bits below a reduced mantissa are zero.
    generate
        if (PAD_W > 0) begin : g_pad_chk
            assert_pad_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (out_a_mant[PAD_W-1:0] == '0) && (out_b_mant[PAD_W-1:0] == '0));
        end
    endgenerate
endmodule

bind fp_operand_unpacker fpu_unpack_checker #(.MANT_W(MANT_W)) u_unpack_chk (.*);

// File: tb/test_fp_operand_unpacker.sv
// Directed bench for the operand unpacker, built with a 7-bit mantissa (16-bit packed operands).
module test_fp_operand_unpacker;
    localparam int MANT_W = 7;
    localparam int OPC_W  = 4;
    localparam int PACK_W = 1 + 8 + MANT_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [OPC_W-1:0]  in_opcode = '0;
    logic [PACK_W-1:0] in_a = '0;
    logic [PACK_W-1:0] in_b = '0;
    logic              out_valid;
    logic [OPC_W-1:0]  out_opcode;
    logic              out_a_sign, out_b_sign;
    logic [23:0]       out_a_mant, out_b_mant;
    logic [7:0]        out_a_exp, out_b_exp;
    logic [4:0]        out_a_flags, out_b_flags;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    fp_operand_unpacker #(.MANT_W(MANT_W), .OPC_W(OPC_W)) i_fp_operand_unpacker (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_opcode(in_opcode),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_opcode(out_opcode),
        .out_a_sign(out_a_sign), .out_a_mant(out_a_mant), .out_a_exp(out_a_exp),
        .out_a_flags(out_a_flags), .out_b_sign(out_b_sign), .out_b_mant(out_b_mant),
        .out_b_exp(out_b_exp), .out_b_flags(out_b_flags)
    );

    always #5 clk = ~clk;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", req, what, act, expv);
        end
    endtask

    // Compare one operand side against expected sign, exponent, mantissa and flags.
    task automatic side(string req, bit is_b, logic s, logic [7:0] e, logic [23:0] m, logic [4:0] f);
        if (!is_b) begin
            chk(req, "a.sign", {31'd0, out_a_sign}, {31'd0, s});
            chk(req, "a.exp", {24'd0, out_a_exp}, {24'd0, e});
            chk(req, "a.mant", {8'd0, out_a_mant}, {8'd0, m});
            chk(req, "a.flags", {27'd0, out_a_flags}, {27'd0, f});
        end else begin
            chk(req, "b.sign", {31'd0, out_b_sign}, {31'd0, s});
            chk(req, "b.exp", {24'd0, out_b_exp}, {24'd0, e});
            chk(req, "b.mant", {8'd0, out_b_mant}, {8'd0, m});
            chk(req, "b.flags", {27'd0, out_b_flags}, {27'd0, f});
        end
    endtask

    // Drive one operation for one edge; return at the following falling edge.
    task automatic apply(logic [OPC_W-1:0] opc, logic [PACK_W-1:0] a, logic [PACK_W-1:0] b);
        @(negedge clk);
        in_valid = 1'b1; in_opcode = opc; in_a = a; in_b = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic test_reset();
        chk("R3", "valid", {31'd0, out_valid}, 32'd0);
        side("R3", 1'b0, 1'b0, 8'h00, 24'h000000, 5'b00001);
        side("R3", 1'b1, 1'b0, 8'h00, 24'h000000, 5'b00001);
    endtask

    task automatic test_normals();
        apply(4'h3, 16'h3F80, 16'hC0A0);
        chk("R1", "valid", {31'd0, out_valid}, 32'd1);
        chk("R1", "opcode", {28'd0, out_opcode}, 32'h3);
        side("R5", 1'b0, 1'b0, 8'h7F, 24'h800000, 5'b00000);
        side("R4", 1'b1, 1'b1, 8'h81, 24'hA00000, 5'b00000);
        apply(4'h5, 16'h7F7F, 16'h0080);
        side("R4", 1'b0, 1'b0, 8'hFE, 24'hFF0000, 5'b00000);
        side("R5", 1'b1, 1'b0, 8'h01, 24'h800000, 5'b00000);
    endtask

    task automatic test_zero_inf();
        apply(4'h6, 16'h8000, 16'h7F80);
        side("R6", 1'b0, 1'b1, 8'h00, 24'h000000, 5'b00001);
        side("R8", 1'b1, 1'b0, 8'hFF, 24'h800000, 5'b00010);
        apply(4'h7, 16'h0000, 16'hFF80);
        side("R6", 1'b0, 1'b0, 8'h00, 24'h000000, 5'b00001);
        side("R8", 1'b1, 1'b1, 8'hFF, 24'h800000, 5'b00010);
    endtask

    task automatic test_sub_nan();
        apply(4'h8, 16'h0001, 16'h7F81);
        side("R7", 1'b0, 1'b0, 8'h01, 24'h010000, 5'b10000);
        side("R9", 1'b1, 1'b0, 8'hFF, 24'h810000, 5'b00100);
        apply(4'h9, 16'h807F, 16'h7FC0);
        side("R7", 1'b0, 1'b1, 8'h01, 24'h7F0000, 5'b10000);
        side("R9", 1'b1, 1'b0, 8'hFF, 24'hC00000, 5'b01000);
        apply(4'hA, 16'hFFC1, 16'h7FBF);
        side("R10", 1'b0, 1'b1, 8'hFF, 24'hC10000, 5'b01000);
        side("R10", 1'b1, 1'b0, 8'hFF, 24'hBF0000, 5'b00100);
    endtask

    task automatic test_hold();
        apply(4'hB, 16'h3F80, 16'h0001);
        @(negedge clk);
        in_a = 16'h7F80; in_b = 16'h0000; in_opcode = 4'h1;
        @(negedge clk);
        chk("R2", "valid", {31'd0, out_valid}, 32'd0);
        chk("R2", "opcode", {28'd0, out_opcode}, 32'hB);
        side("R2", 1'b0, 1'b0, 8'h7F, 24'h800000, 5'b00000);
        side("R2", 1'b1, 1'b0, 8'h01, 24'h010000, 5'b10000);
    endtask

    task automatic test_back_to_back();
        @(negedge clk);
        in_valid = 1'b1; in_opcode = 4'hC; in_a = 16'h0000; in_b = 16'h7FC0;
        @(negedge clk);
        chk("R1", "valid first", {31'd0, out_valid}, 32'd1);
        chk("R1", "opcode first", {28'd0, out_opcode}, 32'hC);
        side("R1", 1'b0, 1'b0, 8'h00, 24'h000000, 5'b00001);
        side("R1", 1'b1, 1'b0, 8'hFF, 24'hC00000, 5'b01000);
        in_opcode = 4'hD; in_a = 16'h7F80; in_b = 16'h0001;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1", "valid second", {31'd0, out_valid}, 32'd1);
        chk("R1", "opcode second", {28'd0, out_opcode}, 32'hD);
        side("R1", 1'b0, 1'b0, 8'hFF, 24'h800000, 5'b00010);
        side("R1", 1'b1, 1'b0, 8'h01, 24'h010000, 5'b10000);
        @(negedge clk);
        chk("R2", "valid after", {31'd0, out_valid}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_normals();
        test_zero_inf();
        test_sub_nan();
        test_hold();
        test_back_to_back();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule